// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block keeps the slot control and slot status registers of a hot-plug capable downstream or root port. Software reaches both registers through a small register port that has byte enables and a one-cycle read latency. Hardware reports a device insertion through a strobe, qualified by whether function 0 of the new device is present. A second strobe reports a press of the attention button.

The block keeps the event bits, which software clears by writing 1. From the status and enable bits it works out a pending-interrupt condition. When MSI is enabled, the block issues a single message request each time that condition rises. When MSI is disabled, it drives a level INTx output that follows the condition. Every write to slot control counts as one command that completes at once and raises command-completed. A write-only control bit toggles the electromechanical interlock. Powering off an occupied slot detaches the device and clears presence and link-active.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, slot control reads 0x00C0, with the attention indicator (bits 7:6) at Off = 2'b11 and every other field 0. Slot status reads 0x0000, and msi_req, intx_out, presence_out, link_active_out and insert_err are all 0.
- R2: Slot control is at address CTL_OFS and slot status at STA_OFS. Any other address reads 0. A read returns its data on reg_rdata in the cycle after reg_rd. A write changes only the bytes whose reg_be lane is set (lane 0 = bits 7:0, lane 1 = bits 15:8).
- R3: Slot control layout and pending condition. The control bits are button enable (bit 0), presence-change enable (bit 3), command-done enable (bit 4), interrupt enable (bit 5), attention indicator (7:6), power indicator (9:8), power off (bit 10) and interlock toggle (bit 11). All other control bits read 0. The interrupt is pending when bit 5 is set and some status event bit in 4:0 is set together with its enable at the same position. With msi_en=1, each 0-to-1 change of the pending condition gives a one-cycle msi_req pulse in the cycle after the causing clock edge. With msi_en=0, intx_out equals the pending condition.
- R4: Slot status layout: button pressed (bit 0), power fault (bit 1), sensor changed (bit 2), presence changed (bit 3), command done (bit 4), presence state (bit 6), interlock engaged (bit 7). Writing 1 clears an event bit in 4:0.
- R5: Raising an event bit that is already set changes nothing and produces no msi_req.
- R6: Every write to slot control with at least one byte lane enabled sets command done (status bit 4).
- R7: Control bit 11 always reads 0. Writing it as 1 toggles status bit 7.
- R8: If a status write tries to clear any event bit that was 0 before the write, the whole write is dropped and the status stays as it was.
- R9: Detach happens when presence state is 1, the new control value has power off (bit 10) = 1 and power indicator = 2'b11, and the old control value did not already have both. On detach, presence state and link-active go to 0 and presence changed goes to 1.
- R10: An insertion strobe with fn0_present=1 sets presence state, link-active, presence changed and button pressed. With fn0_present=0 the strobe changes nothing.
- R11: While status bit 7 is 1, an insertion strobe is rejected: insert_err pulses for one cycle and the status does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_be | input | 2 | Byte-lane enables for writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| insert_req | input | 1 | Device insertion strobe |
| fn0_present | input | 1 | Qualifier: function 0 of inserted device present |
| button_req | input | 1 | Attention button strobe |
| msi_en | input | 1 | MSI enabled |
| msi_req | output | 1 | One-cycle MSI request |
| intx_out | output | 1 | Legacy interrupt level |
| presence_out | output | 1 | Presence detect state |
| link_active_out | output | 1 | Data link layer link active |
| insert_err | output | 1 | Insertion rejected because interlock engaged |

## Verification
The bench writes a status value that clears one set bit and one clear bit at once. A design without the undo rule would lose the set bit. It presses the button a second time while button-pressed is still set. A design that notifies on every post instead of on a change of the pending condition would send a second message. It writes the power-off command twice. A design that fails to compare against the old control value would detach a freshly inserted device on the repeated write. It also inserts a device while the interlock is engaged and once without function 0, and checks in both cases that presence stays clear.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W = 16;
  // slot status bit positions
  localparam int S_ABP = 0;
  localparam int S_PDC = 3;
  localparam int S_CC  = 4;
  localparam int S_PDS = 6;
  localparam int S_EIS = 7;
  // slot control bit positions
  localparam int C_HPIE = 5;
  localparam int C_PCC  = 10;
  localparam int C_EIC  = 11;
  localparam int N_EVT  = 5;
  localparam logic [REG_W-1:0] EVT_MASK  = 16'h001F;
  localparam logic [REG_W-1:0] CTL_WMASK = 16'h07F9;
  localparam logic [REG_W-1:0] CTL_RST   = 16'h00C0;
  localparam logic [1:0]       IND_OFF   = 2'b11;
endpackage

// File: rtl/hp_slot_ctl_reg.sv
module hp_slot_ctl_reg
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic [1:0]       be,
  input  logic [REG_W-1:0] wdata,
  input  logic             pds,
  output logic [REG_W-1:0] ctl_q,
  output logic             cmd_done,
  output logic             eic_toggle,
  output logic             detach
);
  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] ctl_d;
  logic             old_off;
  logic             new_off;

  always_comb begin
    merged = ctl_q;
    if (be[0]) merged[7:0]  = wdata[7:0];
    if (be[1]) merged[15:8] = wdata[15:8];
    ctl_d      = wr_ctl ? (merged & CTL_WMASK) : ctl_q;
    old_off    = ctl_q[C_PCC] && (ctl_q[9:8] == IND_OFF);
    new_off    = merged[C_PCC] && (merged[9:8] == IND_OFF);
    cmd_done   = wr_ctl;
    eic_toggle = wr_ctl && be[1] && wdata[C_EIC];
    detach     = wr_ctl && pds && new_off && !old_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else if (wr_ctl) ctl_q <= ctl_d;
  end

  // R7: the toggle bit never lands in the register
  a_r7_eic_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> !ctl_q[C_EIC]);
endmodule

// File: rtl/hp_slot_sta_reg.sv
module hp_slot_sta_reg
  import hp_slot_pkg::*;
#(
  parameter bit LINK_RPT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sta,
  input  logic [1:0]       be,
  input  logic [REG_W-1:0] wdata,
  input  logic             cmd_done,
  input  logic             eic_toggle,
  input  logic             detach,
  input  logic             insert_req,
  input  logic             fn0_present,
  input  logic             button_req,
  output logic [REG_W-1:0] sta_q,
  output logic             lnk_q,
  output logic             ins_err_q
);
  logic [REG_W-1:0] lanes;
  logic [REG_W-1:0] wr_bits;
  logic [REG_W-1:0] sta_d;
  logic             undo;
  logic             ins_ok;
  logic             lnk_d;
  logic             err_d;
  logic             hw_any;

  always_comb begin
    lanes   = {{8{be[1]}}, {8{be[0]}}};
    wr_bits = wdata & lanes & EVT_MASK;
    undo    = wr_sta && ((wr_bits & ~sta_q) != '0);
    ins_ok  = insert_req && fn0_present && !sta_q[S_EIS];
    err_d   = insert_req && sta_q[S_EIS];
    sta_d   = sta_q;
    if (wr_sta && !undo) sta_d = sta_q & ~wr_bits;
    if (eic_toggle) sta_d[S_EIS] = ~sta_q[S_EIS];
    if (detach) begin
      sta_d[S_PDS] = 1'b0;
      sta_d[S_PDC] = 1'b1;
    end
    if (cmd_done) sta_d[S_CC] = 1'b1;
    if (ins_ok) begin
      sta_d[S_PDS] = 1'b1;
      sta_d[S_PDC] = 1'b1;
      sta_d[S_ABP] = 1'b1;
    end
    if (button_req) sta_d[S_ABP] = 1'b1;
    lnk_d = lnk_q;
    if (detach) lnk_d = 1'b0;
    if (ins_ok && LINK_RPT) lnk_d = 1'b1;
    hw_any = cmd_done || eic_toggle || detach || ins_ok || button_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q     <= '0;
      lnk_q     <= 1'b0;
      ins_err_q <= 1'b0;
    end else begin
      sta_q     <= sta_d;
      lnk_q     <= lnk_d;
      ins_err_q <= err_d;
    end
  end

  // R6: a control write always leaves command-done set
  a_r6_cmd_sets_cc: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> sta_q[S_CC]);
  // R8: software alone can never set an event bit
  a_r8_sw_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sta && !hw_any) |=> ((sta_q & EVT_MASK & ~$past(sta_q)) == '0));
  // R9: detach drops presence and link
  a_r9_detach: assert property (@(posedge clk) disable iff (!rst_n)
    (detach && !ins_ok) |=> (!sta_q[S_PDS] && !lnk_q && sta_q[S_PDC]));
  // R10: accepted insertion raises presence and both events
  a_r10_insert: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ok |=> (sta_q[S_PDS] && sta_q[S_PDC] && sta_q[S_ABP]));
  // R11: locked insertion flags an error
  a_r11_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (insert_req && sta_q[S_EIS]) |=> ins_err_q);
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hpie,
  input  logic [N_EVT-1:0] evt_en,
  input  logic [N_EVT-1:0] evt_sta,
  input  logic             msi_en,
  output logic             msi_req,
  output logic             intx
);
  logic pending;
  logic pend_q;

  always_comb begin
    pending = hpie && ((evt_en & evt_sta) != '0);
    msi_req = msi_en && pending && !pend_q;
    intx    = !msi_en && pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pending;
  end

  // R3: one message per rising edge of the pending condition
  a_r3_msi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |=> !msi_req);
  a_r3_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    !(msi_req && intx));
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CTL_OFS  = 4'h8,
  parameter logic [ADDR_W-1:0] STA_OFS  = 4'hA,
  parameter bit                LINK_RPT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        reg_be,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              insert_req,
  input  logic              fn0_present,
  input  logic              button_req,
  input  logic              msi_en,
  output logic              msi_req,
  output logic              intx_out,
  output logic              presence_out,
  output logic              link_active_out,
  output logic              insert_err
);
  logic             wr_ctl;
  logic             wr_sta;
  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] sta_q;
  logic             cmd_done;
  logic             eic_toggle;
  logic             detach;
  logic             lnk_q;
  logic [REG_W-1:0] rdata_d;
  logic [REG_W-1:0] rdata_q;

  assign wr_ctl = reg_wr && (reg_addr == CTL_OFS) && (reg_be != 2'b00);
  assign wr_sta = reg_wr && (reg_addr == STA_OFS) && (reg_be != 2'b00);

  hp_slot_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .be(reg_be), .wdata(reg_wdata),
    .pds(sta_q[S_PDS]), .ctl_q(ctl_q), .cmd_done(cmd_done),
    .eic_toggle(eic_toggle), .detach(detach)
  );

  hp_slot_sta_reg #(.LINK_RPT(LINK_RPT)) u_sta (
    .clk(clk), .rst_n(rst_n), .wr_sta(wr_sta), .be(reg_be), .wdata(reg_wdata),
    .cmd_done(cmd_done), .eic_toggle(eic_toggle), .detach(detach),
    .insert_req(insert_req), .fn0_present(fn0_present), .button_req(button_req),
    .sta_q(sta_q), .lnk_q(lnk_q), .ins_err_q(insert_err)
  );

  hp_slot_notify u_ntf (
    .clk(clk), .rst_n(rst_n), .hpie(ctl_q[C_HPIE]), .evt_en(ctl_q[N_EVT-1:0]),
    .evt_sta(sta_q[N_EVT-1:0]), .msi_en(msi_en), .msi_req(msi_req),
    .intx(intx_out)
  );

  always_comb begin
    rdata_d = '0;
    if (reg_addr == CTL_OFS) begin
      rdata_d        = ctl_q;
      rdata_d[C_EIC] = 1'b0;
    end else if (reg_addr == STA_OFS) begin
      rdata_d = sta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata       = rdata_q;
  assign presence_out    = sta_q[S_PDS];
  assign link_active_out = lnk_q;

  // R7: the interlock toggle bit reads back as zero
  a_r7_eic_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == CTL_OFS) |=> !reg_rdata[C_EIC]);
  // R2: read data holds between reads
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/tb_hp_slot_ctrl.sv
`timescale 1ns/1ps
module tb_hp_slot_ctrl;
  localparam logic [3:0] CTL = 4'h8;
  localparam logic [3:0] STA = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [1:0]  reg_be = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        insert_req = 1'b0;
  logic        fn0_present = 1'b0;
  logic        button_req = 1'b0;
  logic        msi_en = 1'b0;
  logic        msi_req, intx_out, presence_out, link_active_out, insert_err;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  hp_slot_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .insert_req(insert_req), .fn0_present(fn0_present),
    .button_req(button_req), .msi_en(msi_en), .msi_req(msi_req),
    .intx_out(intx_out), .presence_out(presence_out),
    .link_active_out(link_active_out), .insert_err(insert_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expectation per completed read
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, reg_rdata, e);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic insert(input logic fn0);
    @(negedge clk);
    insert_req = 1'b1; fn0_present = fn0;
    @(negedge clk);
    insert_req = 1'b0;
  endtask

  task automatic press();
    @(negedge clk);
    button_req = 1'b1;
    @(negedge clk);
    button_req = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 msi", {15'd0, msi_req}, 16'd0);
    chk("R1 intx", {15'd0, intx_out}, 16'd0);
    chk("R1 presence", {15'd0, presence_out}, 16'd0);
    chk("R1 link", {15'd0, link_active_out}, 16'd0);
    rd(CTL, 16'h00C0, "R1 ctl reset");
    rd(STA, 16'h0000, "R1 sta reset");
    rd(4'h0, 16'h0000, "R2 unmapped");
    // R2/R6 lane-0 write of enables, command done raises INTx
    wr(CTL, 2'b01, 16'h0038);
    chk("R3 intx on cc", {15'd0, intx_out}, 16'd1);
    rd(STA, 16'h0010, "R6 cc set");
    rd(CTL, 16'h0038, "R2 lane write");
    wr(STA, 2'b01, 16'h0010);
    chk("R3 intx off", {15'd0, intx_out}, 16'd0);
    rd(STA, 16'h0000, "R4 w1c cc");
    // R8 undo
    press();
    wr(STA, 2'b01, 16'h0009);
    rd(STA, 16'h0001, "R8 undo");
    wr(STA, 2'b01, 16'h0001);
    rd(STA, 16'h0000, "R4 w1c abp");
    // R7 interlock
    wr(CTL, 2'b10, 16'h0800);
    rd(CTL, 16'h0038, "R7 eic reads 0");
    rd(STA, 16'h0090, "R7 eis toggled");
    insert(1'b1);
    chk("R11 err", {15'd0, insert_err}, 16'd1);
    chk("R11 presence", {15'd0, presence_out}, 16'd0);
    rd(STA, 16'h0090, "R11 sta unchanged");
    wr(CTL, 2'b10, 16'h0800);
    rd(STA, 16'h0010, "R7 eis back");
    wr(STA, 2'b01, 16'h0010);
    // R10 insertion
    insert(1'b0);
    chk("R10 no fn0", {15'd0, presence_out}, 16'd0);
    rd(STA, 16'h0000, "R10 no fn0 sta");
    insert(1'b1);
    chk("R10 presence", {15'd0, presence_out}, 16'd1);
    chk("R10 link", {15'd0, link_active_out}, 16'd1);
    chk("R10 no err", {15'd0, insert_err}, 16'd0);
    chk("R3 intx pdc", {15'd0, intx_out}, 16'd1);
    rd(STA, 16'h0049, "R10 sta");
    wr(STA, 2'b01, 16'h0009);
    rd(STA, 16'h0040, "R4 w1c two");
    // MSI mode
    msi_en = 1'b1;
    press();
    chk("R3 msi masked", {15'd0, msi_req}, 16'd0);
    wr(CTL, 2'b01, 16'h0039);
    chk("R3 msi rise", {15'd0, msi_req}, 16'd1);
    chk("R3 no intx", {15'd0, intx_out}, 16'd0);
    @(negedge clk);
    chk("R3 msi one cycle", {15'd0, msi_req}, 16'd0);
    press();
    chk("R5 repeat post", {15'd0, msi_req}, 16'd0);
    rd(STA, 16'h0051, "R5 sta same");
    wr(STA, 2'b01, 16'h0001);
    chk("R3 still pending", {15'd0, msi_req}, 16'd0);
    wr(STA, 2'b01, 16'h0010);
    press();
    chk("R3 msi again", {15'd0, msi_req}, 16'd1);
    wr(STA, 2'b01, 16'h0001);
    // R9 detach
    wr(CTL, 2'b11, 16'h0739);
    chk("R9 presence", {15'd0, presence_out}, 16'd0);
    chk("R9 link", {15'd0, link_active_out}, 16'd0);
    chk("R3 msi detach", {15'd0, msi_req}, 16'd1);
    rd(STA, 16'h0018, "R9 sta");
    wr(STA, 2'b01, 16'h0018);
    insert(1'b1);
    wr(STA, 2'b01, 16'h0009);
    wr(CTL, 2'b11, 16'h0739);
    chk("R9 no repeat", {15'd0, presence_out}, 16'd1);
    rd(STA, 16'h0050, "R9 no repeat sta");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule